// File: doc/BRIEF.md
# CPU-side PRG bank mapper

This block sits between a console CPU's 16-bit address bus and the cartridge memories. Every bus cycle it sorts the address into one of four windows: unmapped, an 8 KB work-RAM window at $6000-$7FFF, a switchable 16 KB ROM window at $8000-$BFFF, and a 16 KB ROM window at $C000-$FFFF that always shows the final ROM bank. For the ROM windows it builds an 18-bit ROM address from a bank number and the low 14 address bits.

CPU writes that land in the upper ROM space do not reach ROM. They load internal control registers instead. The upper address nibble picks the target. $A selects the 4-bit switchable bank. $F selects the 1-bit nametable arrangement. $B to $E select four external picture-bank registers. For those four, the block emits only a one-cycle write strobe and a 2-bit index, and a separate picture-bank switcher takes the data byte straight from the bus. Register writes take the CPU data unchanged. Reads anywhere in $8000-$FFFF still enable the ROM.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `cpu_valid` is high and the address is in $6000-$7FFF, `ram_ce` is 1, `rom_ce` is 0 and `ram_addr` equals address bits [12:0].
- R2: While `cpu_valid` is high and the address is in $8000-$FFFF, `rom_ce` is 1 and `ram_ce` is 0, for reads and writes alike. Below $6000, or while `cpu_valid` is low, both enables are 0.
- R3: For addresses $8000-$BFFF, `prg_rom_addr` equals {bank register, address[13:0]}.
- R4: For addresses $C000-$FFFF, `prg_rom_addr` equals {4'hF, address[13:0]}, whatever the bank register holds.
- R5: A write in $A000-$AFFF loads `cpu_data[3:0]` into the bank register at that clock edge. A write is a cycle with `cpu_valid` and `cpu_we` both high. Data bits [7:4] are ignored.
- R6: A write in $F000-$FFFF loads `cpu_data[0]` into the mirroring register at that clock edge. `mirror_horiz` shows it: 0 means vertical, 1 means horizontal. The other data bits are ignored.
- R7: During a write in $B000-$BFFF, $C000-$CFFF, $D000-$DFFF or $E000-$EFFF, `chr_wr_stb` is 1 in that same cycle. `chr_wr_idx` is then 0, 1, 2 or 3 in that order. In all other cycles `chr_wr_stb` is 0.
- R8: Reset (synchronous, active high) clears the bank register and the mirroring register to 0.
- R9: A cycle with `cpu_we` low or `cpu_valid` low changes neither register, even when its address is in $A000-$AFFF or $F000-$FFFF.
- R10: A write whose address is outside $A000-$AFFF leaves the bank register unchanged. A write whose address is outside $F000-$FFFF leaves the mirroring register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_valid | input | 1 | Bus cycle valid |
| prg_rom_addr | output | 18 | Banked ROM address |
| rom_ce | output | 1 | ROM chip enable |
| ram_ce | output | 1 | Work-RAM chip enable |
| ram_addr | output | 13 | Work-RAM address |
| mirror_horiz | output | 1 | Nametable arrangement, 1 = horizontal |
| chr_wr_stb | output | 1 | Picture-bank register write strobe |
| chr_wr_idx | output | 2 | Picture-bank register index |

## Verification
The hardest case is to show that the fixed upper window ignores the bank register. Reading $C000-$FFFF right after reset shows nothing, because reset bank 0 and fixed bank 15 are both valid-looking values and a broken mux could still match by chance.

The stimulus therefore loads each of the 16 bank values in turn. The values come with random upper data bits. After each load, the bench sweeps every 256-byte page of the address space and checks both windows and the enables.

It also issues reads, unflagged cycles and writes to neighbouring slices of the register ranges. It then checks at the outputs that neither register changed.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;
    localparam int WIN_AW    = 14;
    localparam int RAM_AW    = 13;
    localparam int CHR_IDX_W = 2;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_RAM,
        WIN_SWAP,
        WIN_FIXED
    } window_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG,
        TGT_CHR0,
        TGT_CHR1,
        TGT_CHR2,
        TGT_CHR3,
        TGT_MIRR
    } target_e;

    typedef struct packed {
        window_e window;
        target_e target;
    } decode_t;

    function automatic window_e window_of(input logic [CPU_AW-1:0] a);
        if (a[15])
            return a[14] ? WIN_FIXED : WIN_SWAP;
        else if (a[14:13] == 2'b11)
            return WIN_RAM;
        else
            return WIN_NONE;
    endfunction

    function automatic target_e target_of(input logic [CPU_AW-1:0] a);
        case (a[15:12])
            4'hA:    return TGT_PRG;
            4'hB:    return TGT_CHR0;
            4'hC:    return TGT_CHR1;
            4'hD:    return TGT_CHR2;
            4'hE:    return TGT_CHR3;
            4'hF:    return TGT_MIRR;
            default: return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prg_addr_decode.sv
module prg_addr_decode
    import prg_map_pkg::*;
(
    input  logic [CPU_AW-1:0]    addr,
    input  logic                 valid,
    input  logic                 we,
    output decode_t              dec,
    output logic                 wr_cycle,
    output logic                 rom_ce,
    output logic                 ram_ce,
    output logic                 chr_stb,
    output logic [CHR_IDX_W-1:0] chr_idx
);
    localparam int NUM_CHR = 1 << CHR_IDX_W;

    logic [NUM_CHR-1:0] chr_hit;

    always_comb begin
        dec.window = window_of(addr);
        dec.target = target_of(addr);
    end

    assign wr_cycle = valid & we;
    assign rom_ce   = valid & ((dec.window == WIN_SWAP) | (dec.window == WIN_FIXED));
    assign ram_ce   = valid & (dec.window == WIN_RAM);

    for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
        assign chr_hit[g] = wr_cycle &
            (dec.target == target_e'(int'(TGT_CHR0) + g));
    end

    assign chr_stb = |chr_hit;

    always_comb begin
        chr_idx = '0;
        for (int i = 0; i < NUM_CHR; i++)
            if (chr_hit[i]) chr_idx = CHR_IDX_W'(i);
    end
endmodule

// File: rtl/prg_ctrl_regs.sv
module prg_ctrl_regs
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cycle,
    input  target_e           target,
    input  logic [CPU_DW-1:0] data,
    output logic [BANK_W-1:0] bank_q,
    output logic              mirror_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q   <= '0;
            mirror_q <= 1'b0;
        end else if (wr_cycle) begin
            if (target == TGT_PRG)  bank_q   <= data[BANK_W-1:0];
            if (target == TGT_MIRR) mirror_q <= data[0];
        end
    end
endmodule

// File: rtl/prg_rom_addr_gen.sv
module prg_rom_addr_gen
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  window_e           window,
    input  logic [BANK_W-1:0] bank,
    input  logic [CPU_AW-1:0] addr,
    output logic [ROM_AW-1:0] rom_addr
);
    localparam logic [BANK_W-1:0] LAST_BANK = '1;

    logic [BANK_W-1:0] sel_bank;

    always_comb begin
        sel_bank = (window == WIN_FIXED) ? LAST_BANK : bank;
        rom_addr = {sel_bank, addr[WIN_AW-1:0]};
    end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [CPU_DW-1:0]    cpu_data,
    input  logic                 cpu_we,
    input  logic                 cpu_valid,
    output logic [ROM_AW-1:0]    prg_rom_addr,
    output logic                 rom_ce,
    output logic                 ram_ce,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 mirror_horiz,
    output logic                 chr_wr_stb,
    output logic [CHR_IDX_W-1:0] chr_wr_idx
);
    decode_t           dec;
    logic              wr_cycle;
    logic [BANK_W-1:0] bank_q;

    prg_addr_decode u_dec (
        .addr     (cpu_addr),
        .valid    (cpu_valid),
        .we       (cpu_we),
        .dec      (dec),
        .wr_cycle (wr_cycle),
        .rom_ce   (rom_ce),
        .ram_ce   (ram_ce),
        .chr_stb  (chr_wr_stb),
        .chr_idx  (chr_wr_idx)
    );

    prg_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_cycle (wr_cycle),
        .target   (dec.target),
        .data     (cpu_data),
        .bank_q   (bank_q),
        .mirror_q (mirror_horiz)
    );

    prg_rom_addr_gen #(.BANK_W(BANK_W)) u_addr (
        .window   (dec.window),
        .bank     (bank_q),
        .addr     (cpu_addr),
        .rom_addr (prg_rom_addr)
    );

    assign ram_addr = cpu_addr[RAM_AW-1:0];
endmodule

// File: rtl/prg_bank_mapper_checker.sv
module prg_bank_mapper_checker
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int ROM_AW = BANK_W + WIN_AW
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CPU_AW-1:0]    cpu_addr,
    input logic [CPU_DW-1:0]    cpu_data,
    input logic                 cpu_we,
    input logic                 cpu_valid,
    input logic [ROM_AW-1:0]    prg_rom_addr,
    input logic                 rom_ce,
    input logic                 ram_ce,
    input logic                 mirror_horiz,
    input logic                 chr_wr_stb
);
    // R1/R2: never both memories enabled
    a_r2_ce_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rom_ce && ram_ce));

    // R4: upper window always shows the last bank
    a_r4_fixed_bank: assert property (@(posedge clk) disable iff (rst)
        (rom_ce && cpu_addr[14]) |-> (prg_rom_addr[ROM_AW-1:WIN_AW] == '1));

    // R5: bank load visible in the lower window on the next cycle
    a_r5_bank_load: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr[15:12] == 4'hA) |=>
        (!rom_ce || cpu_addr[14] ||
         prg_rom_addr[ROM_AW-1:WIN_AW] == $past(cpu_data[BANK_W-1:0])));

    // R6: mirroring load
    a_r6_mirror_load: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr[15:12] == 4'hF) |=>
        (mirror_horiz == $past(cpu_data[0])));

    // R7: strobe only during a write cycle
    a_r7_stb_on_write: assert property (@(posedge clk) disable iff (rst)
        chr_wr_stb |-> (cpu_valid && cpu_we));

    // R9: no write, no mirroring change
    a_r9_mirror_hold: assert property (@(posedge clk) disable iff (rst)
        !(cpu_valid && cpu_we) |=> $stable(mirror_horiz));

    // R8: reset clears mirroring
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> !mirror_horiz);
endmodule

bind prg_bank_mapper prg_bank_mapper_checker #(.BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .cpu_we       (cpu_we),
    .cpu_valid    (cpu_valid),
    .prg_rom_addr (prg_rom_addr),
    .rom_ce       (rom_ce),
    .ram_ce       (ram_ce),
    .mirror_horiz (mirror_horiz),
    .chr_wr_stb   (chr_wr_stb)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [17:0] prg_rom_addr;
    logic        rom_ce, ram_ce, mirror_horiz, chr_wr_stb;
    logic [12:0] ram_addr;
    logic [1:0]  chr_wr_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prg_bank_mapper u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_we(cpu_we), .cpu_valid(cpu_valid), .prg_rom_addr(prg_rom_addr),
        .rom_ce(rom_ce), .ram_ce(ram_ce), .ram_addr(ram_addr),
        .mirror_horiz(mirror_horiz), .chr_wr_stb(chr_wr_stb),
        .chr_wr_idx(chr_wr_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%0h expected=%0h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic we, input logic vld);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = we; cpu_valid = vld;
        @(negedge clk);
        cpu_we = 1'b0; cpu_valid = 1'b0;
    endtask

    // read-sweep checks lower window against expected bank
    task automatic read_probe(input logic [15:0] a, input int bank);
        int exp_addr;
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b0; cpu_valid = 1'b1;
        #2;
        exp_addr = ((a < 16'hC000) ? bank : 15) * 16384 + (a & 16'h3FFF);
        check("R1 ram_ce", ram_ce, (a >= 16'h6000 && a < 16'h8000));
        check("R2 rom_ce", rom_ce, (a >= 16'h8000));
        if (a >= 16'h6000 && a < 16'h8000) check("R1 ram_addr", ram_addr, a & 16'h1FFF);
        if (a >= 16'h8000 && a < 16'hC000) check("R3 swap addr", prg_rom_addr, exp_addr);
        if (a >= 16'hC000) check("R4 fixed addr", prg_rom_addr, exp_addr);
        check("R7 no stb on read", chr_wr_stb, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R8: reset values
        read_probe(16'h8123, 0);
        check("R8 mirror reset", mirror_horiz, 0);

        // R1..R5 sweep: every bank, every page
        for (int b = 0; b < 16; b++) begin
            bus_write(16'hA000 | 16'((b * 97) & 16'h0FFF), 8'((b * 53) & 8'hF0) | 8'(b), 1'b1, 1'b1);
            for (int p = 0; p < 256; p++)
                read_probe(16'((p << 8) | ((p * 37 + b) & 8'hFF)), b);
        end

        // R2: invalid cycles enable nothing
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_valid = 1'b0; #2;
        check("R2 rom_ce invalid", rom_ce, 0);
        cpu_addr = 16'h7000; #2;
        check("R2 ram_ce invalid", ram_ce, 0);

        // bank now 15; set to 6
        bus_write(16'hAFFF, 8'hA6, 1'b1, 1'b1);
        read_probe(16'h8000, 6);
        // R9: read, unflagged write
        bus_write(16'hA000, 8'h03, 1'b0, 1'b1);
        read_probe(16'hBFFF, 6);
        bus_write(16'hA000, 8'h03, 1'b1, 1'b0);
        read_probe(16'h8555, 6);
        // R10: neighbouring slices
        bus_write(16'h9FFF, 8'h02, 1'b1, 1'b1);
        bus_write(16'hB000, 8'h02, 1'b1, 1'b1);
        bus_write(16'hF000, 8'h02, 1'b1, 1'b1);
        read_probe(16'hA123, 6);

        // R6: mirroring
        bus_write(16'hF123, 8'hFF, 1'b1, 1'b1);
        #2 check("R6 mirror set", mirror_horiz, 1);
        bus_write(16'hFFFF, 8'hFE, 1'b1, 1'b1);
        #2 check("R6 mirror bit0 only", mirror_horiz, 0);
        bus_write(16'hF800, 8'h01, 1'b1, 1'b1);
        #2 check("R6 mirror set again", mirror_horiz, 1);
        bus_write(16'hF000, 8'h00, 1'b0, 1'b1);
        #2 check("R9 mirror read hold", mirror_horiz, 1);
        bus_write(16'hEFFF, 8'h00, 1'b1, 1'b1);
        #2 check("R10 mirror hold", mirror_horiz, 1);
        read_probe(16'h8000, 6);

        // R7: strobe over all nibbles with writes
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            cpu_addr = 16'(n << 12) | 16'h0ABC; cpu_data = 8'h00;
            cpu_we = 1'b1; cpu_valid = 1'b1;
            #2;
            check("R7 chr stb", chr_wr_stb, (n >= 11 && n <= 14));
            if (n >= 11 && n <= 14) check("R7 chr idx", chr_wr_idx, n - 11);
            cpu_valid = 1'b0; #1;
            check("R7 stb needs valid", chr_wr_stb, 0);
        end
        @(negedge clk);
        cpu_we = 1'b0;
        read_probe(16'h8000, 6);

        // R8: reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_probe(16'h8001, 0);
        check("R8 mirror reset again", mirror_horiz, 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule